// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the slave side of a two-wire serial memory. It samples SCL and SDA with a fast system clock, finds START and STOP conditions, and answers a device-select byte. The select byte carries a fixed four-bit family code and three bits that must match strap pins. After a write select, two address bytes load an internal address counter. Further bytes are staged in a page buffer. After a read select, bytes come out of the memory, starting at the address counter.

The slave never drives SDA high. It drives only a pull-down enable, and the board or the bench supplies the pull-up. A STOP that ends a write holding at least one accepted data byte starts an internal write cycle. The cycle copies the staged bytes into the array and lasts a fixed number of clocks. While it runs, the slave refuses its select byte, so a master can poll until the slave answers again. A write-protect input is sampled once per write, at one particular SCL edge, and blocks that whole write.

The array is a synchronous RAM. It is filled with 0xFF when the design starts. Its default size is 2 KiB (MEM_ADDR_W = 11). Setting MEM_ADDR_W = 14 gives a 16 KiB part.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset `sda_pd_o` is 0, and the slave stays silent until it sees a START.
- R2: A select byte is accepted only if bits 7..4 are 1010 and bits 3..1 equal `strap_i[2:0]`. Bit 0 gives the direction: 1 means read, 0 means write. The slave ACKs an accepted select by holding SDA low in the ninth clock. Any other select byte gets no ACK, and the slave ignores the bus until the next START.
- R3: After a write select, the slave ACKs the next two bytes, high byte first, and loads them as the address. Only the low MEM_ADDR_W bits are kept; higher bits of the high byte are ignored. Each data byte after that is ACKed, and the array is written only after the STOP that ends the write.
- R4: `sda_pd_o` changes only while SCL is low. Read data leaves MSB first. Each bit appears after a falling SCL edge and is valid while SCL is high.
- R5: Write data fills a 2^PAGE_W byte page. The offset within the page increments after each byte and wraps to 0 at the page end, so the page number never changes. A later byte at the same offset replaces the earlier one.
- R6: After a STOP that ends a write with at least one accepted data byte, the slave NACKs every select byte for WRITE_CYCLES clocks. After that, it ACKs the select byte again.
- R7: `wp_i` is sampled at the falling SCL edge that ends the ACK of the second address byte. If it is high, every data byte of that write is NACKed, the array is unchanged, and no write cycle follows. A change on `wp_i` after that edge has no effect on the write in progress.
- R8: A write select, two address bytes, a repeated START and a read select together return data starting at the given address.
- R9: A read select with no address phase returns the byte at the address counter. The counter advances by one for each byte sent.
- R10: During a read, the address runs across page boundaries and wraps from 2^MEM_ADDR_W−1 to 0.
- R11: When the master does not ACK a read byte, the slave releases SDA and drives nothing until the next START.
- R12: A START or STOP in the middle of a byte aborts the transfer and discards the partial byte. A START then begins a new select byte, and an aborted data byte starts no write cycle.
- R13: Locations that have never been written read as 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the bus |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Serial clock line level (asynchronous) |
| sda_i | input | 1 | Serial data line level (asynchronous) |
| sda_pd_o | output | 1 | Open-drain pull-down enable for SDA (1 = drive low) |
| strap_i | input | 3 | Board strap pins matched against select bits 3..1 |
| wp_i | input | 1 | Write-protect level (asynchronous) |

## Verification
Each line passes through a two-flop synchronizer and an edge register, so the slave reacts about three clocks after the line changes. `sda_pd_o` then changes in the following clock, so an ACK or a data bit appears about four clocks after the falling SCL edge that calls for it. The bench changes SDA a quarter bit period (ten clocks) after a falling SCL edge. It samples the line in the middle of the SCL high phase, more than twenty clocks after that edge, so every result has settled well before it is read. The write-protect level is changed at the same point as data, ten clocks after the sampling edge. This places it clearly after the sample point. Busy state is checked by polling: the first poll right after the STOP must get a NACK, and a later poll must get an ACK within a fixed number of tries.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SEL,
    PH_AHI,
    PH_ALO,
    PH_WDAT,
    PH_RDAT
  } phase_t;

  localparam logic [3:0] FAMILY_CODE = 4'b1010;
  localparam int         FRAME_BITS  = 8;
endpackage

// File: rtl/eeprom_line_sync.sv
module eeprom_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic scl_s,
  output logic sda_s,
  output logic wp_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_pipe, sda_pipe, wp_pipe;
  logic         scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      wp_pipe  <= '0;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
      sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
      wp_pipe  <= {wp_pipe[TOP-1:0], wp_i};
      scl_prev <= scl_pipe[TOP];
      sda_prev <= sda_pipe[TOP];
    end
  end

  assign scl_s    = scl_pipe[TOP];
  assign sda_s    = sda_pipe[TOP];
  assign wp_s     = wp_pipe[TOP];
  assign scl_rise = scl_s & ~scl_prev;
  assign scl_fall = ~scl_s & scl_prev;
  assign start_ev = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_ev  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/eeprom_proto_fsm.sv
module eeprom_proto_fsm
  import eeprom_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     scl_rise,
  input  logic                     scl_fall,
  input  logic                     start_ev,
  input  logic                     stop_ev,
  input  logic                     sda_s,
  input  logic                     wp_s,
  input  logic [2:0]               strap,
  input  logic                     busy,
  input  logic [7:0]               rd_data,
  output logic                     sda_pd,
  output logic [ADDR_W-1:0]        rd_addr,
  output logic                     buf_we,
  output logic [PAGE_W-1:0]        buf_idx,
  output logic [7:0]               buf_wdata,
  output logic                     buf_clear,
  output logic                     commit_req,
  output logic [ADDR_W-PAGE_W-1:0] page_base,
  output phase_t                   phase,
  output logic [3:0]               bit_cnt,
  output logic                     wp_lock
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [3:0] ACK_SLOT = 4'(FRAME_BITS);
  localparam logic [3:0] END_SLOT = 4'(FRAME_BITS + 1);

  logic [7:0]        rx_sh;
  logic [6:0]        tx_sh;
  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PAGE_W-1:0] off_q;
  logic              is_read, pending, m_nack;
  logic              sel_hit;

  assign sel_hit = (rx_sh[7:4] == FAMILY_CODE) && (rx_sh[3:1] == strap) && !busy;
  assign rd_addr = addr_q;

  always_ff @(posedge clk) begin
    buf_we     <= 1'b0;
    buf_clear  <= 1'b0;
    commit_req <= 1'b0;
    if (rst) begin
      phase     <= PH_IDLE;
      bit_cnt   <= '0;
      sda_pd    <= 1'b0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      hi_q      <= '0;
      addr_q    <= '0;
      off_q     <= '0;
      page_base <= '0;
      is_read   <= 1'b0;
      pending   <= 1'b0;
      m_nack    <= 1'b0;
      wp_lock   <= 1'b0;
      buf_idx   <= '0;
      buf_wdata <= '0;
    end else if (start_ev) begin
      phase   <= PH_SEL;
      bit_cnt <= '0;
      sda_pd  <= 1'b0;
      if (pending) buf_clear <= 1'b1;
      pending <= 1'b0;
    end else if (stop_ev) begin
      phase   <= PH_IDLE;
      bit_cnt <= '0;
      sda_pd  <= 1'b0;
      if (pending) commit_req <= 1'b1;
      pending <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (scl_rise) begin
        if (bit_cnt < ACK_SLOT) rx_sh <= {rx_sh[6:0], sda_s};
        if (bit_cnt == ACK_SLOT) m_nack <= sda_s;
        if (bit_cnt < END_SLOT) bit_cnt <= bit_cnt + 4'd1;
      end else if (scl_fall) begin
        if (bit_cnt == ACK_SLOT) begin
          unique case (phase)
            PH_SEL: begin
              if (sel_hit) begin
                sda_pd  <= 1'b1;
                is_read <= rx_sh[0];
              end else begin
                phase   <= PH_IDLE;
                bit_cnt <= '0;
              end
            end
            PH_AHI: begin
              sda_pd <= 1'b1;
              hi_q   <= rx_sh[HI_W-1:0];
            end
            PH_ALO: begin
              sda_pd <= 1'b1;
              addr_q <= {hi_q, rx_sh};
            end
            PH_WDAT: begin
              if (!wp_lock) begin
                sda_pd    <= 1'b1;
                buf_we    <= 1'b1;
                buf_idx   <= off_q;
                buf_wdata <= rx_sh;
                off_q     <= off_q + 1'b1;
                pending   <= 1'b1;
              end
            end
            default: sda_pd <= 1'b0;
          endcase
        end else if (bit_cnt == END_SLOT) begin
          bit_cnt <= '0;
          sda_pd  <= 1'b0;
          unique case (phase)
            PH_SEL: begin
              if (is_read) begin
                phase  <= PH_RDAT;
                tx_sh  <= rd_data[6:0];
                sda_pd <= ~rd_data[7];
                addr_q <= addr_q + 1'b1;
              end else begin
                phase <= PH_AHI;
              end
            end
            PH_AHI: phase <= PH_ALO;
            PH_ALO: begin
              phase     <= PH_WDAT;
              wp_lock   <= wp_s;
              page_base <= addr_q[ADDR_W-1:PAGE_W];
              off_q     <= addr_q[PAGE_W-1:0];
            end
            PH_RDAT: begin
              if (!m_nack) begin
                tx_sh  <= rd_data[6:0];
                sda_pd <= ~rd_data[7];
                addr_q <= addr_q + 1'b1;
              end else begin
                phase <= PH_IDLE;
              end
            end
            default: phase <= phase;
          endcase
        end else if (bit_cnt != 4'd0 && phase == PH_RDAT) begin
          sda_pd <= ~tx_sh[6];
          tx_sh  <= {tx_sh[5:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W       = 11,
  parameter int PAGE_W       = 6,
  parameter int WRITE_CYCLES = 1024
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     buf_we,
  input  logic [PAGE_W-1:0]        buf_idx,
  input  logic [7:0]               buf_wdata,
  input  logic                     buf_clear,
  input  logic                     commit_req,
  input  logic [ADDR_W-PAGE_W-1:0] page_base,
  output logic                     busy,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_waddr,
  output logic [7:0]               mem_wdata
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int HOLD  = (WRITE_CYCLES > PAGE + 2) ? WRITE_CYCLES : PAGE + 2;
  localparam int TMR_W = $clog2(HOLD + 1);

  logic [7:0]               pbuf [PAGE];
  logic [PAGE-1:0]          valid;
  logic [TMR_W-1:0]         timer;
  logic [PAGE_W:0]          scan;
  logic [ADDR_W-PAGE_W-1:0] page_q;
  logic                     scan_act;
  logic [7:0]               rd_q;
  logic [PAGE_W-1:0]        idx_q;
  logic                     en_q;

  assign scan_act = busy && (scan < (PAGE_W + 1)'(PAGE));

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_idx] <= buf_wdata;
    rd_q  <= pbuf[scan[PAGE_W-1:0]];
    idx_q <= scan[PAGE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= '0;
      busy   <= 1'b0;
      timer  <= '0;
      scan   <= '0;
      page_q <= '0;
      en_q   <= 1'b0;
    end else begin
      en_q <= scan_act && valid[scan[PAGE_W-1:0]];
      if (commit_req) begin
        busy   <= 1'b1;
        timer  <= '0;
        scan   <= '0;
        page_q <= page_base;
      end else if (busy) begin
        if (scan_act) scan <= scan + 1'b1;
        if (timer == TMR_W'(HOLD - 1)) begin
          busy  <= 1'b0;
          valid <= '0;
        end else begin
          timer <= timer + 1'b1;
        end
      end else if (buf_clear) begin
        valid <= '0;
      end else if (buf_we) begin
        valid[buf_idx] <= 1'b1;
      end
    end
  end

  assign mem_we    = en_q;
  assign mem_waddr = {page_q, idx_q};
  assign mem_wdata = rd_q;
endmodule

// File: rtl/eeprom_mem_array.sv
module eeprom_mem_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int MEM_ADDR_W   = 11,
  parameter int PAGE_W       = 6,
  parameter int WRITE_CYCLES = 1024,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pd_o,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  localparam int PG_NUM_W = MEM_ADDR_W - PAGE_W;

  logic                  scl_s, sda_s, wp_s;
  logic                  scl_rise, scl_fall, start_ev, stop_ev;
  logic                  busy;
  logic [7:0]            rd_data;
  logic [MEM_ADDR_W-1:0] rd_addr;
  logic                  buf_we, buf_clear, commit_req;
  logic [PAGE_W-1:0]     buf_idx;
  logic [7:0]            buf_wdata;
  logic [PG_NUM_W-1:0]   page_base;
  phase_t                phase;
  logic [3:0]            bit_cnt;
  logic                  wp_lock;
  logic                  mem_we;
  logic [MEM_ADDR_W-1:0] mem_waddr;
  logic [7:0]            mem_wdata;

  eeprom_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .wp_i(wp_i),
    .scl_s(scl_s), .sda_s(sda_s), .wp_s(wp_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  eeprom_proto_fsm #(.ADDR_W(MEM_ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
    .clk(clk), .rst(rst),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .sda_s(sda_s), .wp_s(wp_s), .strap(strap_i), .busy(busy),
    .rd_data(rd_data), .sda_pd(sda_pd_o), .rd_addr(rd_addr),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
    .buf_clear(buf_clear), .commit_req(commit_req), .page_base(page_base),
    .phase(phase), .bit_cnt(bit_cnt), .wp_lock(wp_lock)
  );

  eeprom_page_writer #(
    .ADDR_W(MEM_ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)
  ) u_pwr (
    .clk(clk), .rst(rst),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
    .buf_clear(buf_clear), .commit_req(commit_req), .page_base(page_base),
    .busy(busy), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  eeprom_mem_array #(.ADDR_W(MEM_ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/eeprom_checks.sv
module eeprom_checks
  import eeprom_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       scl_s,
  input logic       sda_pd_o,
  input logic       busy,
  input phase_t     phase,
  input logic [3:0] bit_cnt,
  input logic       wp_lock,
  input logic       buf_we,
  input logic       mem_we,
  input logic       start_ev
);
  // R4: the pull-down is only switched on while the synchronized clock is low
  assert_pd_rise_scl_low_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pd_o) |-> !scl_s);

  // R6: the slave stays off the bus for the whole internal write cycle
  assert_busy_silent_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_pd_o);

  // R6: the array is only written inside a write cycle
  assert_mem_write_in_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R7: a locked write never reaches the page buffer
  assert_wp_blocks_buffer_R7: assert property (@(posedge clk) disable iff (rst)
    (wp_lock && phase == PH_WDAT) |-> !buf_we);

  // R11: an idle slave releases the line
  assert_idle_released_R11: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> !sda_pd_o);

  // R12: a start restarts the bit framing with the line released
  assert_start_restarts_R12: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> (bit_cnt == 4'd0 && !sda_pd_o && phase == PH_SEL));

  // R2: the bit counter stays inside one nine-clock frame
  assert_frame_range_R2: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= 4'd9);
endmodule

bind serial_eeprom_slave eeprom_checks u_checks (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_pd_o(sda_pd_o), .busy(busy),
  .phase(phase), .bit_cnt(bit_cnt), .wp_lock(wp_lock), .buf_we(buf_we),
  .mem_we(mem_we), .start_ev(start_ev)
);

// File: tb/tb_serial_eeprom_slave.sv
module tb_serial_eeprom_slave;
  localparam int AW   = 11;
  localparam int MEM  = 1 << AW;
  localparam int PAGE = 64;
  localparam int Q    = 10;
  localparam int HALF = 20;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] SELW = {4'hA, STRAP, 1'b0};
  localparam logic [7:0] SELR = {4'hA, STRAP, 1'b1};
  localparam logic [7:0] HI_NOISE = ~8'((1 << (AW - 8)) - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_pd;
  wire  sda_line = sda_m & ~sda_pd;

  always #2.5 clk = ~clk;

  serial_eeprom_slave dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pd_o(sda_pd), .strap_i(STRAP), .wp_i(wp)
  );

  logic [7:0] model [MEM];
  int         model_ctr = 0;
  logic [7:0] wdat [8];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] obs_q [$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_item(input logic [7:0] e, input logic [7:0] o, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    obs_q.push_back(o);
  endtask

  // monitor: pops expected and observed items and compares them
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && obs_q.size() > 0) begin
        logic [7:0] e, o;
        string t;
        e = exp_q.pop_front();
        o = obs_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (e !== o) begin
          n_bad++;
          $display("FAIL %s: actual %02h expected %02h", t, o, e);
        end
      end
    end
  end

  task automatic start_c();
    if (!scl_m) begin
      sda_m = 1'b1; wcyc(Q);
      scl_m = 1'b1; wcyc(HALF);
    end
    sda_m = 1'b0; wcyc(HALF);
    scl_m = 1'b0; wcyc(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wcyc(Q);
    scl_m = 1'b1; wcyc(HALF);
    sda_m = 1'b1; wcyc(HALF);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b;    wcyc(Q);
    scl_m = 1'b1; wcyc(Q);
    s = sda_line; wcyc(Q);
    scl_m = 1'b0; wcyc(Q);
  endtask

  task automatic xmit(input logic [7:0] b, output logic ackv);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, ackv);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_nack, input string tag);
    logic a;
    xmit(b, a);
    expect_item({7'd0, exp_nack}, {7'd0, a}, tag);
  endtask

  task automatic recv_byte(input logic [7:0] e, input logic mnack, input string tag);
    logic [7:0] v;
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      v[i] = s;
    end
    expect_item(e, v, tag);
    clk_bit(mnack, s);
    sda_m = 1'b1;
  endtask

  task automatic set_addr(input int a, input string tag);
    start_c();
    send_byte(SELW, 1'b0, tag);
    send_byte(8'(a >> 8) | HI_NOISE, 1'b0, tag);
    send_byte(8'(a), 1'b0, tag);
  endtask

  task automatic random_read(input int a, input int n, input string tag);
    set_addr(a, "R8");
    start_c();
    send_byte(SELR, 1'b0, "R8");
    for (int k = 0; k < n; k++)
      recv_byte(model[(a + k) & (MEM - 1)], (k == n - 1), tag);
    stop_c();
    model_ctr = (a + n) & (MEM - 1);
  endtask

  task automatic cur_read(input int n, input string tag);
    start_c();
    send_byte(SELR, 1'b0, tag);
    for (int k = 0; k < n; k++)
      recv_byte(model[(model_ctr + k) & (MEM - 1)], (k == n - 1), tag);
    stop_c();
    model_ctr = (model_ctr + n) & (MEM - 1);
  endtask

  // R6: first poll right after the stop is refused, later one is accepted
  task automatic poll_ready();
    logic a;
    int tries;
    start_c();
    send_byte(SELW, 1'b1, "R6");
    stop_c();
    tries = 0;
    do begin
      start_c();
      xmit(SELW, a);
      stop_c();
      tries++;
    end while (a && tries < 12);
    expect_item(8'd0, {7'd0, a}, "R6");
  endtask

  task automatic write_page(input int a, input int n);
    int base;
    base = a & ~(PAGE - 1);
    set_addr(a, "R3");
    for (int k = 0; k < n; k++) begin
      send_byte(wdat[k], 1'b0, "R3");
      model[base | ((a + k) & (PAGE - 1))] = wdat[k];
    end
    stop_c();
    poll_ready();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic s;
    logic [7:0] v;
    for (int i = 0; i < MEM; i++) model[i] = 8'hFF;
    wcyc(10);
    rst = 1'b0;
    wcyc(10);
    expect_item(8'd0, {7'd0, sda_pd}, "R1");

    // R2: wrong strap, then wrong family code, both ignored
    start_c();
    send_byte({4'hA, 3'b011, 1'b0}, 1'b1, "R2");
    send_byte(8'h00, 1'b1, "R2");
    stop_c();
    start_c();
    send_byte({4'hB, STRAP, 1'b1}, 1'b1, "R2");
    stop_c();

    // R13: erased contents
    random_read(16, 1, "R13");

    // R3/R5: page write crossing the page end wraps to the page start
    wdat[0] = 8'hA1; wdat[1] = 8'hA2; wdat[2] = 8'hA3; wdat[3] = 8'hA4;
    write_page(16'h03E, 4);

    // R10: read runs past the page end; R5: wrapped bytes at page start
    random_read(16'h03E, 3, "R10");
    random_read(16'h000, 2, "R5");

    // R9: current address continues after the last byte read
    cur_read(1, "R9");
    random_read(16'h03E, 1, "R4");
    cur_read(1, "R9");

    // R12: start in mid-select restarts framing
    start_c();
    clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s);
    start_c();
    send_byte(SELR, 1'b0, "R12");
    recv_byte(model[model_ctr], 1'b1, "R12");
    stop_c();
    model_ctr = (model_ctr + 1) & (MEM - 1);

    // R10: wrap at the end of memory
    wdat[0] = 8'h5C;
    write_page(MEM - 1, 1);
    random_read(MEM - 1, 2, "R10");

    // R7: protected write refused, no busy phase afterwards
    wp = 1'b1;
    set_addr(16'h100, "R7");
    send_byte(8'h77, 1'b1, "R7");
    stop_c();
    wp = 1'b0;
    start_c();
    send_byte(SELW, 1'b0, "R7");
    stop_c();
    random_read(16'h100, 1, "R7");

    // R7: protect raised after the sample edge does not block
    set_addr(16'h101, "R7");
    wp = 1'b1;
    send_byte(8'h66, 1'b0, "R7");
    model[16'h101] = 8'h66;
    stop_c();
    wp = 1'b0;
    poll_ready();
    random_read(16'h101, 1, "R7");

    // R11: after a master NACK the slave drives nothing
    set_addr(16'h101, "R8");
    start_c();
    send_byte(SELR, 1'b0, "R8");
    recv_byte(8'h66, 1'b1, "R11");
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      v[i] = s;
    end
    expect_item(8'hFF, v, "R11");
    stop_c();

    // R12: stop inside a data byte starts no write cycle
    set_addr(16'h200, "R12");
    clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
    stop_c();
    start_c();
    send_byte(SELW, 1'b0, "R12");
    stop_c();
    random_read(16'h200, 1, "R12");

    wcyc(50);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule